// File: doc/BRIEF.md
# Pin-Change Interrupt Controller

This block watches twelve general-purpose input pins and raises an interrupt request when any enabled pin changes level. The pins form two groups. Pins 3 to 0 belong to group 0 and pins 11 to 4 belong to group 1. Each pin has its own mask bit. Each group has an enable bit and a pending flag. Software reaches the enable, flag and mask registers over a small byte-wide register bus at fixed addresses.

Every pin passes through a two-flop synchroniser before edge detection. When an unmasked pin changes, its group's flag is set. A group drives its request line while its flag, its enable and the global interrupt-enable input are all one. Software clears a flag by writing a one to it. The CPU can also clear it by acknowledging that group's vector.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, all four registers read 0x00 and both request outputs are low.
- R2: A change on any of pins 3..0 can set only flag bit 0. A change on any of pins 11..4 can set only flag bit 1.
- R3: Both rising and falling changes set the flag. The flag reads one exactly three clock edges after the pin changes, and not earlier (two synchroniser stages plus one edge-detect stage).
- R4: Mask register 0 is at 0x6B. Bits 3..0 enable pins 3..0, and bits 7..4 read zero. Mask register 1 is at 0x6C, where bit i enables pin i+4. A change on a masked pin never sets a flag, even when the mask bit is set after the change.
- R5: The control register is at 0x68. Bit 0 enables group 0 and bit 1 enables group 1. Bits 7..2 read zero and ignore writes.
- R6: The flag register is at 0x3B. Bit 0 is the group 0 flag and bit 1 is the group 1 flag. Writing a one to a flag bit clears it. Writing a zero leaves it unchanged. Bits 7..2 read zero.
- R7: irq[g] is high exactly when flag g, enable g and gie are all one. It follows the registers with no added delay.
- R8: ack[g] held high for one clock edge clears flag g and leaves the other flag unchanged.
- R9: When a new change and a clear (write-one or ack) reach the same flag on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 12 | Asynchronous pin levels |
| gie | input | 1 | Global interrupt enable |
| ack | input | 2 | Per-group acknowledge from the CPU |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational on addr) |
| irq | output | 2 | Per-group interrupt request |

## Verification
A flag can be set by a detected change and cleared by a write-one or an acknowledge on the same clock edge. The bench sets a flag first. It then toggles a second pin of the same group and waits two edges, so that the edge-detect pulse is live. On the third edge it presents a write-one to the flag register, and in a second case an acknowledge. It judges the case correct when the flag still reads one afterwards, and checks that a later plain clear does empty it.

// File: rtl/pin_change_irq.sv
`timescale 1ns/1ps
module pin_change_irq #(
  parameter int          G0_PINS    = 4,
  parameter int          G1_PINS    = 8,
  parameter logic [7:0]  CTRL_ADDR  = 8'h68,
  parameter logic [7:0]  FLAG_ADDR  = 8'h3B,
  parameter logic [7:0]  MASK0_ADDR = 8'h6B,
  parameter logic [7:0]  MASK1_ADDR = 8'h6C
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [G0_PINS+G1_PINS-1:0] pin_in,
  input  logic                       gie,
  input  logic [1:0]                 ack,
  input  logic                       wr_en,
  input  logic [7:0]                 addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic [1:0]                 irq
);
  localparam int NPINS = G0_PINS + G1_PINS;

  logic [NPINS-1:0]   sync_a, sync_b, sync_prev;
  logic [G0_PINS-1:0] mask0;
  logic [G1_PINS-1:0] mask1;
  logic [1:0]         enable, flag, grp_hit, clr;
  logic [NPINS-1:0]   edge_seen;
  logic               wr_flag;

  assign edge_seen  = sync_b ^ sync_prev;
  assign grp_hit[0] = |(edge_seen[G0_PINS-1:0] & mask0);
  assign grp_hit[1] = |(edge_seen[NPINS-1:G0_PINS] & mask1);
  assign wr_flag    = wr_en && (addr == FLAG_ADDR);
  assign clr        = ack | ({2{wr_flag}} & wdata[1:0]);
  assign irq        = flag & enable & {2{gie}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      sync_prev <= '0;
      flag      <= '0;
      enable    <= '0;
      mask0     <= '0;
      mask1     <= '0;
    end else begin
      sync_a    <= pin_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
      flag      <= grp_hit | (flag & ~clr);
      if (wr_en) begin
        if (addr == CTRL_ADDR)  enable <= wdata[1:0];
        if (addr == MASK0_ADDR) mask0  <= wdata[G0_PINS-1:0];
        if (addr == MASK1_ADDR) mask1  <= wdata[G1_PINS-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR)  rdata[1:0]         = enable;
    if (addr == FLAG_ADDR)  rdata[1:0]         = flag;
    if (addr == MASK0_ADDR) rdata[G0_PINS-1:0] = mask0;
    if (addr == MASK1_ADDR) rdata[G1_PINS-1:0] = mask1;
  end
endmodule

// File: rtl/pin_change_irq_chk.sv
`timescale 1ns/1ps
module pin_change_irq_chk #(
  parameter logic [7:0] CTRL_ADDR = 8'h68,
  parameter logic [7:0] FLAG_ADDR = 8'h3B
) (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic [1:0] ack,
  input logic       wr_en,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [1:0] irq,
  input logic [1:0] flag,
  input logic [1:0] grp_hit,
  input logic [1:0] enable
);
  // R7
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq == 2'b00);
  // R7
  irq_needs_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> (flag[0] && enable[0]));
  // R9
  set_wins_g0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_hit[0] |=> flag[0]);
  // R9
  set_wins_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_hit[1] |=> flag[1]);
  // R6
  wone_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == FLAG_ADDR && wdata[0] && !grp_hit[0]) |=> !flag[0]);
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && !grp_hit[1]) |=> !flag[1]);
  // R5
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTRL_ADDR) |-> rdata[7:2] == 6'd0);
endmodule

bind pin_change_irq pin_change_irq_chk #(.CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ack(ack), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .flag(flag), .grp_hit(grp_hit),
  .enable(enable)
);

// File: tb/sim_pin_change_irq.sv
`timescale 1ns/1ps
module sim_pin_change_irq;
  localparam logic [7:0] A_CTRL = 8'h68, A_FLAG = 8'h3B, A_M0 = 8'h6B, A_M1 = 8'h6C;

  logic clk = 1'b0, rst_n = 1'b0, gie = 1'b0, wr_en = 1'b0;
  logic [11:0] pin_in = '0;
  logic [1:0]  ack = '0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pin_change_irq u0 (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gie(gie), .ack(ack),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1; step(1); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(3); rst_n = 1'b1; step(1);
    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
    rd(A_FLAG, v); check("R1 flag", v, 8'h00);
    rd(A_M0, v);   check("R1 mask0", v, 8'h00);
    rd(A_M1, v);   check("R1 mask1", v, 8'h00);
    check("R1 irq", {6'd0, irq}, 8'h00);
    // R5 control reserved bits
    wr(A_CTRL, 8'hFF); rd(A_CTRL, v); check("R5 ctrl readback", v, 8'h03);
    wr(A_CTRL, 8'h00);
    // R4 mask readback
    wr(A_M0, 8'hFF); rd(A_M0, v); check("R4 mask0 readback", v, 8'h0F);
    wr(A_M1, 8'hA5); rd(A_M1, v); check("R4 mask1 readback", v, 8'hA5);
    // R6 write on empty flags, reserved bits
    wr(A_FLAG, 8'hFF); rd(A_FLAG, v); check("R6 flag reserved", v, 8'h00);

    // R2 R3 R4 sweep over every pin, both masks, both directions
    for (int p = 0; p < 12; p++) begin
      for (int m = 0; m < 2; m++) begin
        logic [11:0] full;
        logic [7:0]  exp;
        full = (m == 1) ? (12'd1 << p) : ~(12'd1 << p);
        wr(A_M0, {4'd0, full[3:0]});
        wr(A_M1, full[11:4]);
        wr(A_FLAG, 8'h03);
        exp = (m == 0) ? 8'h00 : ((p < 4) ? 8'h01 : 8'h02);
        for (int d = 0; d < 2; d++) begin
          pin_in[p] = ~pin_in[p];
          step(2); rd(A_FLAG, v);
          check($sformatf("R3 latency pin%0d dir%0d", p, d), v, 8'h00);
          step(1); rd(A_FLAG, v);
          check($sformatf("R2/R4 pin%0d mask%0d dir%0d", p, m, d), v, exp);
          wr(A_FLAG, 8'h03);
        end
      end
    end

    // R4 mask enabled after change
    wr(A_M0, 8'h00); wr(A_M1, 8'h00);
    pin_in[5] = ~pin_in[5]; step(4);
    wr(A_M1, 8'hFF); step(2);
    rd(A_FLAG, v); check("R4 late mask", v, 8'h00);

    // set both flags
    wr(A_M0, 8'h0F);
    pin_in[0] = ~pin_in[0]; pin_in[4] = ~pin_in[4]; step(3);
    rd(A_FLAG, v); check("R2 both groups", v, 8'h03);
    // R7 gating sweep
    for (int i = 0; i < 8; i++) begin
      logic [2:0] c;
      c = 3'(i);
      gie = c[2]; wr(A_CTRL, {6'd0, c[1:0]});
      check($sformatf("R7 irq gie%0d en%0d", c[2], c[1:0]), {6'd0, irq},
            c[2] ? {6'd0, c[1:0]} : 8'h00);
    end
    // R6 write zero, partial write one
    wr(A_FLAG, 8'h00); rd(A_FLAG, v); check("R6 write zero", v, 8'h03);
    wr(A_FLAG, 8'h01); rd(A_FLAG, v); check("R6 clear bit0", v, 8'h02);
    check("R7 irq after clear", {6'd0, irq}, 8'h02);
    // R8 ack clears only its group
    pin_in[1] = ~pin_in[1]; step(3);
    ack = 2'b01; step(1); ack = 2'b00;
    rd(A_FLAG, v); check("R8 ack group0", v, 8'h02);
    ack = 2'b10; step(1); ack = 2'b00;
    rd(A_FLAG, v); check("R8 ack group1", v, 8'h00);

    // R9 set vs write-one clear on the same edge
    pin_in[0] = ~pin_in[0]; step(3);
    pin_in[2] = ~pin_in[2]; step(2);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, v); check("R9 set beats write-one", v, 8'h01);
    wr(A_FLAG, 8'h01); rd(A_FLAG, v); check("R9 later clear", v, 8'h00);
    // R9 set vs ack
    pin_in[4] = ~pin_in[4]; step(3);
    pin_in[6] = ~pin_in[6]; step(2);
    ack = 2'b10; step(1); ack = 2'b00;
    rd(A_FLAG, v); check("R9 set beats ack", v, 8'h02);
    ack = 2'b10; step(1); ack = 2'b00;
    rd(A_FLAG, v); check("R9 ack later", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule